// File: doc/BRIEF.md
# Interrupt Enable and Acceptance Controller

This block decides when a small CPU core may take an interrupt. It holds one global master enable flag and one enable flag for each maskable source. Software reaches these flags through a byte-wide register window. The flags can be read back in full, so the core's read-modify-write bit operations work on them.

Sources with an index below `NPSEUDO` are pseudo non-maskable. No flag can mask them. When any source is taken, the block saves the master flag for the core to stack, clears the master flag, and then takes no further source until the core reports that the acknowledge is complete. Four strobes also change the master flag:
- Enable sets it.
- Disable clears it.
- The maskable return sets it.
- The non-maskable return reloads it with the value the core pops from the stack.

Request latches, vector fetch, the stack and instruction decode are outside this block.

Top module: `irq_accept_ctl`

## Requirements
- R1: While the master flag is 0, no source with an index of `NPSEUDO` or above is taken, whatever its enable flag holds.
- R2: While the master flag is 1, a maskable source is taken only if its own enable flag is 1. Among such sources that request at once, the lowest index is taken first.
- R3: A requesting source with an index below `NPSEUDO` is taken whatever the master and per-source flags hold. It outranks every maskable source, and the lowest index among these sources wins.
- R4: A source is taken in the clock cycle in which it is chosen. At the next edge `accept_o` is high for exactly one cycle, `accept_idx_o` carries the source index, `saved_imf_o` carries the master flag as it was before the acceptance, and the master flag reads 0.
- R5: After an acceptance, no further source is taken until a cycle with `ack_done_i` high. The first new acceptance can be chosen in the cycle after that one.
- R6: The maskable return strobe sets the master flag to 1 at the next edge. An enabled request that is still pending is then chosen in the following cycle, so `accept_o` rises two edges after the cycle with the strobe.
- R7: The non-maskable return strobe loads the master flag from `retn_imf_i`. A stacked value of 0 leaves interrupts masked.
- R8: The enable strobe sets the master flag and the disable strobe clears it. When strobes coincide, the precedence is:
  - the non-maskable return wins over all others;
  - enable and maskable return win over disable;
  - any strobe wins over a register write to bit 0.
- R9: After reset the master flag and every per-source enable flag are 0, `accept_o` is 0, and every register byte reads 0.
- R10: Register byte `a` holds flag bits `8a` to `8a+7`, with bit `k` of the byte holding flag `8a+k`:
  - Bit 0 of byte 0 is the master flag.
  - Flag positions 1 to `NPSEUDO-1`, and those at `NSRC` or above, always read 0 and ignore writes.
  - Every other bit reads back exactly what was last written.
- R11: If a source is taken in the same cycle as a register write to byte 0, the master flag ends at 0. A per-source enable write in the cycle of an acceptance still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | NSRC | Latched request lines, one per source index |
| ei_i | input | 1 | Enable strobe: set the master flag |
| di_i | input | 1 | Disable strobe: clear the master flag |
| reti_i | input | 1 | Maskable return strobe: set the master flag |
| retn_i | input | 1 | Non-maskable return strobe: reload the master flag |
| retn_imf_i | input | 1 | Stacked master flag value used by the non-maskable return |
| ack_done_i | input | 1 | Core has finished acknowledging the last acceptance |
| reg_wr_i | input | 1 | Register byte write enable |
| reg_addr_i | input | AW | Register byte index |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` (combinational) |
| accept_o | output | 1 | One-cycle acceptance pulse |
| accept_idx_o | output | IW | Index of the source taken |
| saved_imf_o | output | 1 | Master flag value before the acceptance, for stacking |

## Verification
An acceptance and a write to the master flag can land in the same clock cycle, and the block must then leave the master flag at 0. The same holds when an acceptance meets an enable or return strobe. The bench provokes this by raising an enabled request in the very cycle that writes 1 to byte 0. It also raises a pseudo non-maskable request in the cycle that writes a per-source flag byte. It then judges the result by reading the master flag back as 0, seeing the pulse with the right index, and reading the new per-source byte back unchanged. A behavioural model runs alongside and compares every output on every cycle. It also covers coinciding strobes and a return that arrives while a request is still pending.

// File: rtl/irq_accept_ctl.sv
module irq_accept_ctl #(
  parameter int NSRC    = 40,
  parameter int NPSEUDO = 3,
  localparam int NBYTE  = (NSRC + 7) / 8,
  localparam int AW     = (NBYTE > 1) ? $clog2(NBYTE) : 1,
  localparam int IW     = $clog2(NSRC),
  localparam int VW     = (1 << AW) * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NSRC-1:0] req_i,
  input  logic          ei_i,
  input  logic          di_i,
  input  logic          reti_i,
  input  logic          retn_i,
  input  logic          retn_imf_i,
  input  logic          ack_done_i,
  input  logic          reg_wr_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [7:0]    reg_wdata_i,
  output logic [7:0]    reg_rdata_o,
  output logic          accept_o,
  output logic [IW-1:0] accept_idx_o,
  output logic          saved_imf_o
);

  logic            imf_q, imf_d;
  logic [NSRC-1:0] src_en_q, src_en_d;
  logic            busy_q;
  logic            pick_vld;
  logic [IW-1:0]   pick_idx;
  logic            take;
  logic [VW-1:0]   view;

  always_comb begin
    pick_vld = 1'b0;
    pick_idx = '0;
    for (int i = NSRC - 1; i >= NPSEUDO; i--) begin
      if (req_i[i] && src_en_q[i] && imf_q) begin
        pick_vld = 1'b1;
        pick_idx = IW'(i);
      end
    end
    for (int i = NPSEUDO - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        pick_vld = 1'b1;
        pick_idx = IW'(i);
      end
    end
  end

  assign take = pick_vld && !busy_q;

  always_comb begin
    src_en_d = src_en_q;
    if (reg_wr_i) begin
      for (int i = NPSEUDO; i < NSRC; i++) begin
        if ((i / 8) == int'(reg_addr_i)) src_en_d[i] = reg_wdata_i[i % 8];
      end
    end
  end

  always_comb begin
    imf_d = imf_q;
    if (reg_wr_i && reg_addr_i == '0) imf_d = reg_wdata_i[0];
    if (di_i)                         imf_d = 1'b0;
    if (ei_i || reti_i)               imf_d = 1'b1;
    if (retn_i)                       imf_d = retn_imf_i;
    if (take)                         imf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imf_q        <= 1'b0;
      src_en_q     <= '0;
      busy_q       <= 1'b0;
      accept_o     <= 1'b0;
      accept_idx_o <= '0;
      saved_imf_o  <= 1'b0;
    end else begin
      imf_q    <= imf_d;
      src_en_q <= src_en_d;
      accept_o <= take;
      if (take) begin
        busy_q       <= 1'b1;
        accept_idx_o <= pick_idx;
        saved_imf_o  <= imf_q;
      end else if (ack_done_i) begin
        busy_q <= 1'b0;
      end
    end
  end

  always_comb begin
    view = '0;
    view[NSRC-1:0] = src_en_q;
    view[0] = imf_q;
  end

  assign reg_rdata_o = view[{reg_addr_i, 3'b000} +: 8];

  AST_MASKED_NEEDS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o && accept_idx_o >= IW'(NPSEUDO)) |-> saved_imf_o); // R1
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> !accept_o); // R4
  AST_MASTER_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |-> !imf_q); // R4
  AST_WAIT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !ack_done_i) |=> !accept_o); // R5
  AST_RETI_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !retn_i && !take) |=> imf_q); // R6
  AST_RETN_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (retn_i && !take) |=> (imf_q == $past(retn_imf_i))); // R7
  AST_DI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (di_i && !ei_i && !reti_i && !retn_i) |=> !imf_q); // R8

endmodule

// File: tb/irq_accept_ctl_tb_top.sv
module irq_accept_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 40;
  localparam int NPS  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0] req = '0;
  logic ei = 0, di = 0, reti = 0, retn = 0, retn_imf = 0, ack = 0;
  logic wr = 0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic acc, saved;
  logic [5:0] idx;

  int checks = 0;
  int fails  = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_accept_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .ei_i(ei), .di_i(di),
    .reti_i(reti), .retn_i(retn), .retn_imf_i(retn_imf), .ack_done_i(ack),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .accept_o(acc), .accept_idx_o(idx), .saved_imf_o(saved)
  );

  // behavioural reference model
  bit m_imf = 0, m_busy = 0, m_acc = 0, m_saved = 0;
  bit [63:0] m_en = '0;
  int m_idx = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_imf = 0; m_en = '0; m_busy = 0; m_acc = 0; m_idx = 0; m_saved = 0;
    end else begin
      int found;
      bit nimf;
      found = -1;
      if (!m_busy) begin
        for (int i = 0; i < NPS; i++) if (req[i] && found < 0) found = i;
        if (found < 0 && m_imf)
          for (int i = NPS; i < NSRC; i++) if (req[i] && m_en[i] && found < 0) found = i;
      end
      nimf = m_imf;
      if (wr && addr == 0) nimf = wdata[0];
      if (di) nimf = 0;
      if (ei || reti) nimf = 1;
      if (retn) nimf = retn_imf;
      if (found >= 0) nimf = 0;
      if (wr) for (int b = 0; b < 8; b++) begin
        int k;
        k = int'(addr) * 8 + b;
        if (k >= NPS && k < NSRC) m_en[k] = wdata[b];
      end
      m_acc = (found >= 0);
      if (found >= 0) begin
        m_idx = found; m_saved = m_imf; m_busy = 1;
      end else if (ack) m_busy = 0;
      m_imf = nimf;
    end
  end

  function automatic logic [7:0] m_read(input int a);
    logic [7:0] v;
    v = m_en[a*8 +: 8];
    if (a == 0) v[0] = m_imf;
    return v;
  endfunction

  task automatic chk(input string rq, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", rq, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4 accept pulse", acc, m_acc);
      if (m_acc) begin
        chk("R2 index", idx, m_idx);
        chk("R4 saved flag", saved, m_saved);
      end
      chk("R10 read data", rdata, m_read(int'(addr)));
    end
  end

  task automatic cyc();
    @(negedge clk); #1;
  endtask

  task automatic wr_byte(input int a, input logic [7:0] d);
    wr = 1; addr = 3'(a); wdata = d; cyc(); wr = 0;
  endtask

  task automatic rd_chk(input int a, input logic [7:0] exp, input string rq);
    addr = 3'(a); #1;
    chk(rq, rdata, exp);
  endtask

  task automatic wait_acc(input int max, output bit got, output int gi, output bit gs);
    got = 0; gi = -1; gs = 0;
    for (int n = 0; n < max && !got; n++) begin
      cyc();
      if (acc) begin got = 1; gi = int'(idx); gs = saved; end
    end
  endtask

  task automatic pulse_ack();
    ack = 1; cyc(); ack = 0;
  endtask

  initial begin
    bit got, gs;
    int gi;
    repeat (3) cyc();
    chk("R9 accept low in reset", acc, 0);
    rst_n = 1;
    cyc();
    chk("R9 accept low after reset", acc, 0);
    for (int a = 0; a < 5; a++) rd_chk(a, 8'h00, "R9 reset byte");

    wr_byte(0, 8'h06);
    rd_chk(0, 8'h00, "R10 unused low bits");
    wr_byte(1, 8'h14);
    rd_chk(1, 8'h14, "R10 byte1 readback");
    wr_byte(4, 8'hFF);
    rd_chk(4, 8'hFF, "R10 top byte readback");
    rd_chk(5, 8'h00, "R10 out of range byte");
    wr_byte(4, 8'h00);

    req[12] = 1; req[20] = 1;
    wait_acc(4, got, gi, gs);
    chk("R1 masked by master", got, 0);

    ei = 1; cyc(); ei = 0;
    wait_acc(4, got, gi, gs);
    chk("R2 enabled source taken", gi, 12);
    chk("R4 saved master", gs, 1);
    rd_chk(0, 8'h00, "R4 master cleared");

    req[1] = 1; req[10] = 1;
    wait_acc(4, got, gi, gs);
    chk("R5 held until ack", got, 0);
    pulse_ack();
    wait_acc(3, got, gi, gs);
    chk("R3 pseudo source taken", gi, 1);
    chk("R3 saved master zero", gs, 0);
    req[1] = 0;
    pulse_ack();

    retn = 1; retn_imf = 0; cyc(); retn = 0;
    rd_chk(0, 8'h00, "R7 restore zero");
    wait_acc(3, got, gi, gs);
    chk("R7 stays masked", got, 0);

    reti = 1; cyc(); reti = 0;
    rd_chk(0, 8'h01, "R6 master set");
    cyc();
    chk("R6 pending taken at once", acc, 1);
    chk("R2 lowest index wins", idx, 10);
    pulse_ack();

    retn = 1; retn_imf = 1; cyc(); retn = 0;
    rd_chk(0, 8'h01, "R7 restore one");
    wait_acc(3, got, gi, gs);
    chk("R7 pending after restore", gi, 10);
    req[10] = 0; req[12] = 0; req[20] = 0;
    pulse_ack();

    ei = 1; di = 1; cyc(); ei = 0; di = 0;
    rd_chk(0, 8'h01, "R8 enable beats disable");
    di = 1; cyc(); di = 0;
    rd_chk(0, 8'h00, "R8 disable");
    di = 1; wr = 1; addr = 0; wdata = 8'h01; cyc(); di = 0; wr = 0;
    rd_chk(0, 8'h00, "R8 strobe beats write");
    ei = 1; cyc(); ei = 0;
    rd_chk(0, 8'h01, "R8 enable");

    req[12] = 1; wr = 1; addr = 0; wdata = 8'h01; cyc(); wr = 0;
    chk("R11 accept with write", acc, 1);
    rd_chk(0, 8'h00, "R11 accept wins master");
    req[12] = 0;
    pulse_ack();

    req[2] = 1; wr = 1; addr = 1; wdata = 8'h40; cyc(); wr = 0;
    chk("R11 pseudo accept idx", idx, 2);
    rd_chk(1, 8'h40, "R11 flag write kept");
    req[2] = 0;
    pulse_ack();
    repeat (3) cyc();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule